// File: doc/BRIEF.md
# Serial Word Collector with Parity

This block gathers a qualified serial bit stream into fixed-width parallel words. On every clock edge where the bit qualifier is high, one serial bit is taken in; bits offered while the qualifier is low are ignored, and the partial word is kept. Once a full word has been taken in, the block registers it on its parallel output and raises a completion strobe for one cycle. In the same cycle it presents the parity of that word, formed by chaining XOR across all of its bits.

Bits fill the word most-significant first. A wrapping bit counter lets a new word start on the cycle right after the previous one ends, so a continuous stream needs no idle slots. The parallel word and the parity stay registered until the next word completes. A synchronous reset throws away any partial word.

Top module: `ser_word_collector`

## Requirements
- R1: A serial bit is taken in only on a rising clock edge where `bit_vld` is 1. Edges with `bit_vld` at 0 change neither the partial word nor the bit count, whatever `ser_bit` carries.
- R2: The first accepted bit of a word appears on `word_out[WORD_W-1]` and the last on `word_out[0]`.
- R3: `word_stb` is 1 for exactly one cycle, in the cycle after the edge that accepts the WORD_W-th bit of a word. It is 0 at all other times.
- R4: A new word can start on the edge right after the one that completed the previous word. Two words streamed with `bit_vld` held high give two strobes exactly WORD_W cycles apart, each with its own correct word.
- R5: `word_out` and `word_par` keep their values in every cycle without a strobe, until the next word completes.
- R6: `word_par` is 1 when the completed word has an odd number of ones and 0 when it has an even number. It is valid in the same cycle as `word_stb`.
- R7: While `rst` is high at a clock edge, `word_out`, `word_par` and `word_stb` are cleared to 0 after that edge.
- R8: Reset discards a partial word. After reset, the first strobe comes only after WORD_W new accepted bits, and it carries only those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifier: take `ser_bit` in on this edge |
| word_out | output | WORD_W | Last completed parallel word, first bit in the MSB |
| word_stb | output | 1 | One-cycle strobe marking a newly completed word |
| word_par | output | 1 | Parity of `word_out` (1 = odd number of ones) |

## Verification
Two events can fall on the same edge. A word can complete while the first bit of the next word is accepted, and reset can arrive while a word is part-built. The first case is provoked by streaming words back to back with the qualifier held high. The bench then checks that the strobe repeats every WORD_W cycles and that each word and parity belongs to the right group of bits. The second case is provoked by reset arriving after a few accepted bits. The bench then checks that no strobe appears until WORD_W fresh bits have arrived, and that the resulting word holds none of the discarded bits.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int DEF_WORD_W = 8;

  function automatic int cnt_width(input int w);
    return (w < 3) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/swc_bit_counter.sv
module swc_bit_counter #(
  parameter int WORD_W = swc_pkg::DEF_WORD_W,
  localparam int CW = swc_pkg::cnt_width(WORD_W)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic last
);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

  logic [CW-1:0] cnt_q;

  assign last = (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/swc_shift_reg.sv
module swc_shift_reg #(
  parameter int WORD_W = swc_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              din,
  output logic [WORD_W-1:0] nxt
);
  // Only WORD_W-1 bits are stored; the final bit joins combinationally.
  logic [WORD_W-2:0] sh_q;

  assign nxt = {sh_q, din};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (en) begin
      sh_q <= nxt[WORD_W-2:0];
    end
  end
endmodule

// File: rtl/swc_parity_tree.sv
module swc_parity_tree #(
  parameter int WORD_W = swc_pkg::DEF_WORD_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              odd
);
  logic [WORD_W-1:0] chain;

  assign chain[0] = word[0];
  for (genvar i = 1; i < WORD_W; i++) begin : g_xor
    assign chain[i] = chain[i-1] ^ word[i];
  end

  assign odd = chain[WORD_W-1];
endmodule

// File: rtl/ser_word_collector.sv
module ser_word_collector #(
  parameter int WORD_W = swc_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic              bit_vld,
  output logic [WORD_W-1:0] word_out,
  output logic              word_stb,
  output logic              word_par
);
  logic              last_bit;
  logic [WORD_W-1:0] word_nxt;
  logic              par_nxt;
  logic              done;

  swc_bit_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (bit_vld),
    .last (last_bit)
  );

  swc_shift_reg #(.WORD_W(WORD_W)) u_sh (
    .clk (clk),
    .rst (rst),
    .en  (bit_vld),
    .din (ser_bit),
    .nxt (word_nxt)
  );

  swc_parity_tree #(.WORD_W(WORD_W)) u_par (
    .word (word_nxt),
    .odd  (par_nxt)
  );

  assign done = bit_vld && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_par <= 1'b0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= done;
      if (done) begin
        word_out <= word_nxt;
        word_par <= par_nxt;
      end
    end
  end
endmodule

// File: rtl/ser_word_collector_chk.sv
module ser_word_collector_chk #(
  parameter int WORD_W = swc_pkg::DEF_WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_vld,
  input logic [WORD_W-1:0] word_out,
  input logic              word_stb,
  input logic              word_par
);
  // R3
  stb_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !word_stb);

  // R3
  stb_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> $past(bit_vld));

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_stb && !$past(rst)) |-> ($stable(word_out) && $stable(word_par)));

  // R6
  par_match_chk: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> (word_par == ^word_out));

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (word_out == '0 && !word_stb && !word_par));
endmodule

bind ser_word_collector ser_word_collector_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_vld  (bit_vld),
  .word_out (word_out),
  .word_stb (word_stb),
  .word_par (word_par)
);

// File: tb/ser_word_collector_bench.sv
`timescale 1ns/1ps
module ser_word_collector_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_bit = 1'b0;
  logic         bit_vld = 1'b0;
  logic [W-1:0] word_out;
  logic         word_stb;
  logic         word_par;

  int checks = 0;
  int fails  = 0;

  // Reference state, kept from the requirements only
  logic [W-1:0] m_sh   = '0;
  int           m_cnt  = 0;
  logic [W-1:0] m_word = '0;
  logic         m_par  = 1'b0;
  int           strobes = 0;

  always #5 clk = ~clk;

  ser_word_collector #(.WORD_W(W)) u_ser_word_collector (
    .clk      (clk),
    .rst      (rst),
    .ser_bit  (ser_bit),
    .bit_vld  (bit_vld),
    .word_out (word_out),
    .word_stb (word_stb),
    .word_par (word_par)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock with given inputs; compare all outputs against the reference
  task automatic push(input logic b, input logic v, input string tag);
    logic exp_stb;
    @(negedge clk);
    ser_bit = b;
    bit_vld = v;
    @(posedge clk);
    #1;
    exp_stb = 1'b0;
    if (v) begin
      m_sh = {m_sh[W-2:0], b};
      m_cnt++;
      if (m_cnt == W) begin
        m_cnt  = 0;
        m_word = m_sh;
        m_par  = ^m_sh;
        exp_stb = 1'b1;
      end
    end
    if (word_stb) strobes++;
    check(word_stb == exp_stb, {tag, " R3 strobe"}, word_stb, exp_stb);
    check(word_out == m_word,  {tag, " R5 word"}, word_out, m_word);
    check(word_par == m_par,   {tag, " R6 parity"}, word_par, m_par);
  endtask

  task automatic send_word(input logic [W-1:0] w, input int gap, input string tag);
    for (int i = W - 1; i >= 0; i--) begin
      push(w[i], 1'b1, tag);
      for (int g = 0; g < gap; g++) push(~w[i], 1'b0, tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_vld = 1'b1;
    ser_bit = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    m_sh = '0; m_cnt = 0; m_word = '0; m_par = 1'b0;
    // R7 outputs cleared
    check(word_out == '0, "R7 word", word_out, 0);
    check(word_stb == 1'b0, "R7 strobe", word_stb, 0);
    check(word_par == 1'b0, "R7 parity", word_par, 0);
    @(negedge clk);
    rst = 1'b0;
    bit_vld = 1'b0;
  endtask

  task automatic t_msb_first();
    send_word(8'hA5, 0, "R2");
    check(word_out == 8'hA5, "R2 order", word_out, 8'hA5);
    send_word(8'h80, 0, "R2");
    check(word_out[W-1] == 1'b1 && word_out[0] == 1'b0, "R2 msb", word_out, 8'h80);
  endtask

  task automatic t_gaps();
    send_word(8'h3C, 2, "R1");
    check(word_out == 8'h3C, "R1 gapped word", word_out, 8'h3C);
    send_word(8'hC3, 1, "R1");
    check(word_out == 8'hC3, "R1 gapped word", word_out, 8'hC3);
  endtask

  task automatic t_back_to_back();
    int s0;
    s0 = strobes;
    send_word(8'hFF, 0, "R4");
    check(word_par == 1'b0, "R4 even parity", word_par, 0);
    send_word(8'h01, 0, "R4");
    check(word_out == 8'h01 && word_par == 1'b1, "R4 second word", word_out, 8'h01);
    check(strobes - s0 == 2, "R4 strobe count", strobes - s0, 2);
  endtask

  task automatic t_parity();
    logic [W-1:0] pats [4] = '{8'h00, 8'h07, 8'h96, 8'hFE};
    for (int i = 0; i < 4; i++) begin
      send_word(pats[i], 0, "R6");
      check(word_par == ^pats[i], "R6 pattern parity", word_par, ^pats[i]);
    end
  endtask

  task automatic t_hold();
    for (int i = 0; i < 6; i++) push(i[0], 1'b0, "R5 idle");
    check(word_out == m_word, "R5 held", word_out, m_word);
  endtask

  task automatic t_discard();
    int s0;
    for (int i = 0; i < 5; i++) push(1'b1, 1'b1, "R8 partial");
    do_reset();
    s0 = strobes;
    for (int i = W - 1; i >= 1; i--) push(1'b0, 1'b1, "R8");
    check(strobes == s0, "R8 no early strobe", strobes - s0, 0);
    push(1'b1, 1'b1, "R8");
    check(word_stb == 1'b1 && word_out == 8'h01, "R8 fresh word", word_out, 8'h01);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_msb_first();
    t_gaps();
    t_back_to_back();
    t_parity();
    t_hold();
    t_discard();
    t_hold();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule